// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler with Postponement

This block decides when a DDR SDRAM controller should spend bus time on an AUTO REFRESH. A free-running divider turns the controller clock into one refresh credit per refresh interval. The credits collect in a backlog counter while the command path is busy. The default interval is 3900 cycles, which is 15.6 us at 4 ns. Across 64 ms this yields 4096 refreshes. Because the device tolerates at most eight outstanding refreshes, the backlog is capped at eight.

When the command path reports idle and all banks are precharged, the scheduler raises a low-priority request. When the backlog is full, it raises an urgent request. The urgent request tells the controller to close its banks and refresh even if traffic is waiting. The urgent request does not depend on the idle or bank inputs, and it stays up until a granted refresh brings the backlog below the cap.

The controller pulses a grant input in the cycle it issues the refresh. An accepted grant removes one credit. It also starts a recovery countdown of the refresh row cycle time (72 ns to 80 ns, 20 cycles by default). While the countdown runs, a busy output tells the controller to keep the device free of other commands. Precharging banks and encoding commands are done by the surrounding controller.

Top module: `arf_scheduler`

## Requirements
- R1: While reset is held, and in the first cycle after it, the backlog is 0 and the low-priority request, the urgent request and busy are all low.
- R2: The first credit appears INTERVAL_CYC clock edges after reset is released. After that, one credit is added every INTERVAL_CYC edges.
- R3: The backlog never exceeds MAX_DEBT (default 8). A credit that arrives when the backlog is already full is dropped.
- R4: The low-priority request goes high on the clock edge that samples cmd_idle and banks_closed both high. The backlog must be between 1 and MAX_DEBT-1 and busy must be low.
- R5: The low-priority request is low when cmd_idle is low, when banks_closed is low, or when the backlog is 0.
- R6: The urgent request is high exactly when the backlog equals MAX_DEBT, whatever cmd_idle and banks_closed are. The low-priority request is never high at the same time.
- R7: A grant is accepted when it is sampled with the backlog at 1 or more, banks_closed high and busy low. An accepted grant lowers the backlog by one on that same edge.
- R8: A grant has no effect on the backlog or on busy when it is sampled with the backlog at 0, with banks_closed low, or with busy high.
- R9: After an accepted grant, busy is high for exactly TRFC_CYC cycles. The low-priority request stays low while busy is high.
- R10: If a credit arrives on the same edge as an accepted grant, the backlog is unchanged. This holds even when the backlog is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_idle | input | 1 | Command path has nothing pending |
| banks_closed | input | 1 | Every bank is in the precharged state |
| ref_grant | input | 1 | Controller issues the AUTO REFRESH this cycle |
| req_lazy | output | 1 | Low-priority refresh request |
| req_urgent | output | 1 | Urgent refresh request; the backlog is full |
| rfc_busy | output | 1 | Refresh recovery time is still running |
| backlog | output | $clog2(MAX_DEBT+1) | Number of postponed refreshes |

## Verification
All outputs are registers, so each result appears after the first rising edge that samples its cause.

- **Request outputs.** A change on cmd_idle, banks_closed or ref_grant shows up on the outputs one edge later.
- **Credits.** A credit changes the backlog on every edge whose count since reset release is a multiple of INTERVAL_CYC.
- **Busy.** After an accepted grant, busy stays high for TRFC_CYC consecutive cycles, starting with the cycle after the grant edge.

**How the bench keeps to this timing.** The bench drives inputs on the falling edge and samples outputs on the next falling edge. It counts edges since reset release, so it knows where every credit lands. Tests that must avoid a credit start just after one. The collision test places its grant on the edge that carries a credit.

// File: rtl/arf_pkg.sv
package arf_pkg;

  // How the backlog counter moves on the next edge.
  typedef enum logic [1:0] {
    DEBT_HOLD = 2'd0,
    DEBT_INC  = 2'd1,
    DEBT_DEC  = 2'd2
  } debt_op_e;

  // Combine a credit arrival and an accepted grant into one counter move.
  function automatic debt_op_e pick_op(input logic credit, input logic take);
    if (credit && !take)      return DEBT_INC;
    else if (take && !credit) return DEBT_DEC;
    else                      return DEBT_HOLD;
  endfunction

endpackage

// File: rtl/arf_interval_timer.sv
module arf_interval_timer #(
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk,
  input  logic rst,
  output logic credit
);
  localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  // The credit fires in the last cycle of each period.
  assign credit = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (credit) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/arf_debt_counter.sv
module arf_debt_counter
  import arf_pkg::*;
#(
  parameter int MAX_DEBT = 8,
  parameter int DW       = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  debt_op_e      op,
  output logic [DW-1:0] level,
  output logic [DW-1:0] level_nxt
);
  localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

  always_comb begin
    level_nxt = level;
    unique case (op)
      DEBT_INC: if (level != FULL)  level_nxt = level + 1'b1;
      DEBT_DEC: if (level != '0)    level_nxt = level - 1'b1;
      default:                      level_nxt = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= level_nxt;
  end
endmodule

// File: rtl/arf_recovery_timer.sv
module arf_recovery_timer #(
  parameter int TRFC_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_nxt,
  output logic busy
);
  localparam int TW = $clog2(TRFC_CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(TRFC_CYC);

  logic [TW-1:0] left_q, left_d;

  always_comb begin
    if (start)             left_d = LOAD;
    else if (left_q != '0) left_d = left_q - 1'b1;
    else                   left_d = '0;
  end

  assign busy_nxt = (left_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      busy   <= 1'b0;
    end else begin
      left_q <= left_d;
      busy   <= busy_nxt;
    end
  end
endmodule

// File: rtl/arf_request_gen.sv
module arf_request_gen #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] level_nxt,
  input  logic          busy_nxt,
  input  logic          cmd_idle,
  input  logic          banks_closed,
  output logic          req_lazy,
  output logic          req_urgent
);
  localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

  logic full_d, lazy_d;

  assign full_d = (level_nxt == FULL);
  assign lazy_d = (level_nxt != '0) && !full_d && cmd_idle && banks_closed && !busy_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_lazy   <= 1'b0;
      req_urgent <= 1'b0;
    end else begin
      req_lazy   <= lazy_d;
      req_urgent <= full_d;
    end
  end
endmodule

// File: rtl/arf_scheduler.sv
module arf_scheduler
  import arf_pkg::*;
#(
  parameter int INTERVAL_CYC = 3900,
  parameter int TRFC_CYC     = 20,
  parameter int MAX_DEBT     = 8,
  localparam int DW          = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_idle,
  input  logic          banks_closed,
  input  logic          ref_grant,
  output logic          req_lazy,
  output logic          req_urgent,
  output logic          rfc_busy,
  output logic [DW-1:0] backlog
);
  logic          credit;
  logic          take;
  logic          busy_nxt;
  logic [DW-1:0] level_nxt;
  debt_op_e      op;

  arf_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk(clk), .rst(rst), .credit(credit)
  );

  // A grant counts only if something is owed, banks are shut and recovery is over.
  assign take = ref_grant && (backlog != '0) && banks_closed && !rfc_busy;
  assign op   = pick_op(credit, take);

  arf_debt_counter #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
    .clk(clk), .rst(rst), .op(op), .level(backlog), .level_nxt(level_nxt)
  );

  arf_recovery_timer #(.TRFC_CYC(TRFC_CYC)) u_rfc (
    .clk(clk), .rst(rst), .start(take), .busy_nxt(busy_nxt), .busy(rfc_busy)
  );

  arf_request_gen #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_req (
    .clk(clk), .rst(rst), .level_nxt(level_nxt), .busy_nxt(busy_nxt),
    .cmd_idle(cmd_idle), .banks_closed(banks_closed),
    .req_lazy(req_lazy), .req_urgent(req_urgent)
  );
endmodule

// File: rtl/arf_scheduler_chk.sv
module arf_scheduler_chk #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = $clog2(MAX_DEBT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          banks_closed,
  input logic          ref_grant,
  input logic          req_lazy,
  input logic          req_urgent,
  input logic          rfc_busy,
  input logic [DW-1:0] backlog
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (backlog == '0 && !req_lazy && !req_urgent && !rfc_busy));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    backlog <= DW'(MAX_DEBT));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (backlog <= $past(backlog) + 1'b1));

  a_r6_urgent_full: assert property (@(posedge clk) disable iff (rst)
    req_urgent == (backlog == DW'(MAX_DEBT)));

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(req_lazy && req_urgent));

  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    rfc_busy |-> !req_lazy);

  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (ref_grant && rfc_busy) |=> (backlog >= $past(backlog)));

  a_r7_grant_starts: assert property (@(posedge clk) disable iff (rst)
    (ref_grant && backlog != '0 && banks_closed && !rfc_busy) |=> rfc_busy);
endmodule

bind arf_scheduler arf_scheduler_chk #(.MAX_DEBT(MAX_DEBT)) u_chk (
  .clk(clk), .rst(rst), .banks_closed(banks_closed), .ref_grant(ref_grant),
  .req_lazy(req_lazy), .req_urgent(req_urgent), .rfc_busy(rfc_busy),
  .backlog(backlog)
);

// File: tb/arf_scheduler_bench.sv
module arf_scheduler_bench;
  localparam int INT  = 40;
  localparam int TRFC = 5;
  localparam int MAXD = 8;
  localparam int DW   = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_idle = 1'b0, banks_closed = 1'b0, ref_grant = 1'b0;
  logic req_lazy, req_urgent, rfc_busy;
  logic [DW-1:0] backlog;

  int checks = 0, errors = 0, edges = 0;
  bit done = 1'b0;

  arf_scheduler #(.INTERVAL_CYC(INT), .TRFC_CYC(TRFC), .MAX_DEBT(MAXD)) u_arf_scheduler (
    .clk(clk), .rst(rst), .cmd_idle(cmd_idle), .banks_closed(banks_closed),
    .ref_grant(ref_grant), .req_lazy(req_lazy), .req_urgent(req_urgent),
    .rfc_busy(rfc_busy), .backlog(backlog)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (!rst) edges <= edges + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edges);
    end
  endtask

  // Move to the falling edge just after a credit landed.
  task automatic sync_after_credit();
    do @(negedge clk); while (edges % INT != 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 backlog in reset", int'(backlog), 0);
    chk("R1 lazy in reset", int'(req_lazy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 backlog after reset", int'(backlog), 0);
    chk("R1 urgent after reset", int'(req_urgent), 0);
    chk("R1 busy after reset", int'(rfc_busy), 0);
  endtask

  task automatic t_interval();
    while (edges < INT - 1) @(negedge clk);
    chk("R2 no credit before interval", int'(backlog), 0);
    @(negedge clk);
    chk("R2 first credit", int'(backlog), 1);
    while (edges < 2 * INT - 1) @(negedge clk);
    chk("R2 no early second credit", int'(backlog), 1);
    @(negedge clk);
    chk("R2 second credit", int'(backlog), 2);
  endtask

  task automatic t_lazy();
    sync_after_credit();
    cmd_idle = 1'b1; banks_closed = 1'b1;
    @(negedge clk);
    chk("R4 lazy raised", int'(req_lazy), 1);
    chk("R6 no urgent below cap", int'(req_urgent), 0);
    cmd_idle = 1'b0;
    @(negedge clk);
    chk("R5 lazy drops with idle low", int'(req_lazy), 0);
    cmd_idle = 1'b1; banks_closed = 1'b0;
    @(negedge clk);
    chk("R5 lazy low with banks open", int'(req_lazy), 0);
    banks_closed = 1'b1;
    @(negedge clk);
    chk("R4 lazy back", int'(req_lazy), 1);
  endtask

  task automatic t_grant();
    int b, n;
    sync_after_credit();
    cmd_idle = 1'b1; banks_closed = 1'b1;
    b = int'(backlog);
    ref_grant = 1'b1;
    @(negedge clk);
    chk("R7 grant takes one", int'(backlog), b - 1);
    chk("R9 busy after grant", int'(rfc_busy), 1);
    chk("R9 lazy low while busy", int'(req_lazy), 0);
    @(negedge clk);
    chk("R8 grant ignored while busy", int'(backlog), b - 1);
    ref_grant = 1'b0;
    n = 2;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rfc_busy) n++; else break;
    end
    chk("R9 busy length", n, TRFC);
    chk("R4 lazy after recovery", int'(req_lazy), 1);
    banks_closed = 1'b0; ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk("R8 grant ignored banks open", int'(backlog), b - 1);
    chk("R8 no busy banks open", int'(rfc_busy), 0);
    banks_closed = 1'b1;
    while (backlog != 0) begin
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      while (rfc_busy) @(negedge clk);
    end
    chk("R5 lazy low at zero backlog", int'(req_lazy), 0);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk("R8 grant ignored at zero", int'(backlog), 0);
    chk("R8 no busy at zero", int'(rfc_busy), 0);
  endtask

  task automatic t_saturate();
    cmd_idle = 1'b0; banks_closed = 1'b0;
    while (backlog != DW'(MAXD)) @(negedge clk);
    chk("R6 urgent at cap", int'(req_urgent), 1);
    cmd_idle = 1'b1; banks_closed = 1'b1;
    @(negedge clk);
    chk("R6 lazy suppressed at cap", int'(req_lazy), 0);
    cmd_idle = 1'b0; banks_closed = 1'b0;
    repeat (2 * INT) @(negedge clk);
    chk("R3 saturated", int'(backlog), MAXD);
    chk("R6 urgent with banks open", int'(req_urgent), 1);
    banks_closed = 1'b1;
    do @(negedge clk); while (edges % INT != INT - 1);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk("R10 credit and grant cancel", int'(backlog), MAXD);
    chk("R10 grant accepted", int'(rfc_busy), 1);
    while (rfc_busy) @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk("R7 grant below cap", int'(backlog), MAXD - 1);
    chk("R6 urgent released", int'(req_urgent), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_interval();
    t_lazy();
    t_grant();
    t_saturate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule